// File: doc/BRIEF.md
# Protected-Mode Segment Register Loader

This unit loads one segment register of a processor running in protected mode. A request carries a 16-bit selector, the id of the destination segment register and the base and limit of the descriptor table that the selector indexes. The unit checks the selector against the table and fetches the 8-byte descriptor as two 32-bit words over a simple read port. It then applies the access-rights rules for the destination, where the stack register is stricter than the other data registers. The result is either one write to an external descriptor cache or one fault report with a fault class and an error code.

A controller raises `start` for one cycle while `busy` is low and waits for the one-cycle `done` pulse. The work is sequenced by a state machine with six states. IDLE waits for a request and latches it on `start` (IDLE to DECODE). DECODE classifies the selector. A null selector goes straight to REPORT, and so does a selector outside the table. Any other selector goes to FETCH_LO. FETCH_LO holds a read of the low descriptor word until it returns (FETCH_LO to FETCH_HI). FETCH_HI does the same for the high word (FETCH_HI to CHECK). CHECK applies the rights rules and prepares either the fault or the cache entry (CHECK to REPORT). REPORT presents the outcome for one cycle (REPORT to IDLE).

Top module: `seg_load_unit`

## Requirements
- R1: After reset the unit is idle: `busy`, `done`, `mem_req`, `cw_en` and `fault` are all low.
- R2: A null selector (bits 15:2 all zero) loaded into a register other than the stack register makes no memory read. It completes with a cache write that holds the selector, base 0, limit 0 and the 32-bit flag clear.
- R3: A null selector loaded into the stack register makes no memory read and reports a general-protection fault.
- R4: The table index is the selector with bits 2:0 cleared. When index + 7 is greater than the table limit, the unit makes no memory read and reports general protection. Otherwise it reads the low word at table base + index and then the high word at table base + index + 4.
- R5: Every fault carries the error code selector AND 0xFFFC. Fault classes are encoded as 1 for general protection, 2 for segment not present and 3 for stack fault.
- R6: A descriptor with high-word bit 12 clear (system descriptor) is rejected with general protection. So is a descriptor with bit 11 set (code) and bit 9 clear (not readable).
- R7: For the stack register, a code descriptor (bit 11 set) is rejected with general protection, and so is a data descriptor whose bit 9 (writable) is clear.
- R8: When every type rule passes but high-word bit 15 (present) is clear, the stack register gets fault class 3 and any other register gets class 2.
- R9: On success the base is built as {high[31:24], high[7:0], low[31:16]}.
- R10: On success the raw limit is {high[19:16], low[15:0]}. When high-word bit 23 (granularity) is set, the limit becomes raw << 12 with the low 12 bits forced to ones.
- R11: On success the 32-bit flag is high-word bit 22.
- R12: Each accepted request ends in exactly one `done` pulse. The pulse carries either a fault or a cache write (`cw_en`) to `cw_idx` equal to the destination id, never both. A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| sel | input | 16 | Selector to load |
| dest_id | input | SEG_ID_W | Destination segment register id |
| tbl_base | input | ADDR_W | Descriptor table base address |
| tbl_limit | input | ADDR_W | Descriptor table limit (last valid byte offset) |
| busy | output | 1 | Request in progress |
| mem_req | output | 1 | Read request, held until `mem_rvalid` |
| mem_addr | output | ADDR_W | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Request ended in a fault (with `done`) |
| fault_class | output | 2 | 1 general protection, 2 not present, 3 stack fault |
| err_code | output | 16 | Fault error code |
| cw_en | output | 1 | Cache entry write strobe (with `done`) |
| cw_idx | output | SEG_ID_W | Register whose cache entry is written |
| cw_sel | output | 16 | Selector stored in the entry |
| cw_base | output | 32 | Segment base |
| cw_limit | output | 32 | Scaled segment limit |
| cw_big | output | 1 | 32-bit default-size flag |

## Verification
On every cycle the assertions check several properties of the outcome. A fault and a cache write never coincide, and `done` never lasts two cycles. Error codes have their two low bits clear, and a stack fault appears only for the stack register. A null entry has a zero base and limit, a granular entry ends its limit in 0xFFF, and no read is issued while idle. The bench scenarios cover the rest. They check the ordering among the rules (null, bounds, type, stack type, presence), the exact read addresses and the number of reads. They also cover the bit-exact reassembly of base and limit and the discarding of a `start` that arrives mid-request.

// File: rtl/seg_load_pkg.sv
package seg_load_pkg;

    // fault class encoding seen at the ports
    typedef enum logic [1:0] {
        FC_NONE  = 2'd0,
        FC_GP    = 2'd1,
        FC_NOSEG = 2'd2,
        FC_STACK = 2'd3
    } fault_cls_e;

    // high descriptor word bit positions
    localparam int HB_TYPE_RW  = 9;
    localparam int HB_CODE     = 11;
    localparam int HB_NONSYS   = 12;
    localparam int HB_PRESENT  = 15;
    localparam int HB_BIG      = 22;
    localparam int HB_GRAN     = 23;

    localparam int SEL_W      = 16;
    localparam int DESC_WORD  = 32;

    typedef struct packed {
        logic [SEL_W-1:0]     sel;
        logic [DESC_WORD-1:0] base;
        logic [DESC_WORD-1:0] limit;
        logic                 big;
    } seg_entry_t;

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
    import seg_load_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [ADDR_W-1:0] tbl_limit,
    output logic              is_null,
    output logic              out_of_range,
    output logic [ADDR_W-1:0] lo_addr,
    output logic [ADDR_W-1:0] hi_addr
);
    localparam int EXT_W = (ADDR_W > SEL_W ? ADDR_W : SEL_W) + 1;

    logic [EXT_W-1:0] idx_ext;
    logic [EXT_W-1:0] last_byte;
    logic [EXT_W-1:0] lim_ext;
    logic [ADDR_W-1:0] idx_addr;

    always_comb begin
        is_null      = (sel[SEL_W-1:2] == '0);
        idx_ext      = EXT_W'({sel[SEL_W-1:3], 3'b000});
        last_byte    = idx_ext + EXT_W'(7);
        lim_ext      = EXT_W'(tbl_limit);
        out_of_range = (last_byte > lim_ext);
        idx_addr     = ADDR_W'({sel[SEL_W-1:3], 3'b000});
        lo_addr      = tbl_base + idx_addr;
        hi_addr      = tbl_base + idx_addr + ADDR_W'(4);
    end

endmodule

// File: rtl/seg_rights_check.sv
module seg_rights_check
    import seg_load_pkg::*;
(
    input  logic [DESC_WORD-1:0] hi_word,
    input  logic                 to_stack,
    output fault_cls_e           verdict
);
    logic is_code, rw_bit, nonsys, present;

    always_comb begin
        is_code = hi_word[HB_CODE];
        rw_bit  = hi_word[HB_TYPE_RW];
        nonsys  = hi_word[HB_NONSYS];
        present = hi_word[HB_PRESENT];
        verdict = FC_NONE;
        if (!nonsys || (is_code && !rw_bit)) begin
            verdict = FC_GP;
        end else if (to_stack && (is_code || !rw_bit)) begin
            verdict = FC_GP;
        end else if (!present) begin
            verdict = to_stack ? FC_STACK : FC_NOSEG;
        end
    end

endmodule

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
    import seg_load_pkg::*;
(
    input  logic [DESC_WORD-1:0] lo_word,
    input  logic [DESC_WORD-1:0] hi_word,
    output logic [DESC_WORD-1:0] seg_base,
    output logic [DESC_WORD-1:0] seg_limit,
    output logic                 seg_big
);
    localparam int RAW_LIM_W = 20;
    localparam int PAGE_SH   = DESC_WORD - RAW_LIM_W;

    logic [RAW_LIM_W-1:0] raw_lim;

    always_comb begin
        seg_base = {hi_word[31:24], hi_word[7:0], lo_word[31:16]};
        raw_lim  = {hi_word[19:16], lo_word[15:0]};
        if (hi_word[HB_GRAN]) begin
            seg_limit = {raw_lim, {PAGE_SH{1'b1}}};
        end else begin
            seg_limit = DESC_WORD'(raw_lim);
        end
        seg_big = hi_word[HB_BIG];
    end

endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
    import seg_load_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SEG_ID_W = 3,
    parameter int STACK_ID = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [15:0]         sel,
    input  logic [SEG_ID_W-1:0] dest_id,
    input  logic [ADDR_W-1:0]   tbl_base,
    input  logic [ADDR_W-1:0]   tbl_limit,
    output logic                busy,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_rvalid,
    input  logic [31:0]         mem_rdata,
    output logic                done,
    output logic                fault,
    output logic [1:0]          fault_class,
    output logic [15:0]         err_code,
    output logic                cw_en,
    output logic [SEG_ID_W-1:0] cw_idx,
    output logic [15:0]         cw_sel,
    output logic [31:0]         cw_base,
    output logic [31:0]         cw_limit,
    output logic                cw_big
);
    typedef enum logic [2:0] {
        S_IDLE,
        S_DECODE,
        S_FETCH_LO,
        S_FETCH_HI,
        S_CHECK,
        S_REPORT
    } state_e;

    state_e state_q, state_d;

    logic [SEL_W-1:0]     sel_q;
    logic [SEG_ID_W-1:0]  dest_q;
    logic [ADDR_W-1:0]    tbase_q;
    logic [ADDR_W-1:0]    tlim_q;
    logic [DESC_WORD-1:0] lo_q;
    logic [DESC_WORD-1:0] hi_q;
    fault_cls_e           res_cls_q;
    seg_entry_t           res_entry_q;

    logic                 to_stack;
    logic                 sel_null;
    logic                 sel_oor;
    logic [ADDR_W-1:0]    lo_addr;
    logic [ADDR_W-1:0]    hi_addr;
    fault_cls_e           rights_cls;
    logic [DESC_WORD-1:0] un_base;
    logic [DESC_WORD-1:0] un_limit;
    logic                 un_big;

    assign to_stack = (dest_q == SEG_ID_W'(STACK_ID));

    seg_sel_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel          (sel_q),
        .tbl_base     (tbase_q),
        .tbl_limit    (tlim_q),
        .is_null      (sel_null),
        .out_of_range (sel_oor),
        .lo_addr      (lo_addr),
        .hi_addr      (hi_addr)
    );

    seg_rights_check u_chk (
        .hi_word  (hi_q),
        .to_stack (to_stack),
        .verdict  (rights_cls)
    );

    seg_desc_unpack u_unp (
        .lo_word   (lo_q),
        .hi_word   (hi_q),
        .seg_base  (un_base),
        .seg_limit (un_limit),
        .seg_big   (un_big)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start) state_d = S_DECODE;
            S_DECODE:   state_d = (sel_null || sel_oor) ? S_REPORT : S_FETCH_LO;
            S_FETCH_LO: if (mem_rvalid) state_d = S_FETCH_HI;
            S_FETCH_HI: if (mem_rvalid) state_d = S_CHECK;
            S_CHECK:    state_d = S_REPORT;
            S_REPORT:   state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // request capture, descriptor words and outcome
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q       <= '0;
            dest_q      <= '0;
            tbase_q     <= '0;
            tlim_q      <= '0;
            lo_q        <= '0;
            hi_q        <= '0;
            res_cls_q   <= FC_NONE;
            res_entry_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        sel_q   <= sel;
                        dest_q  <= dest_id;
                        tbase_q <= tbl_base;
                        tlim_q  <= tbl_limit;
                    end
                end
                S_DECODE: begin
                    res_entry_q     <= '0;
                    res_entry_q.sel <= sel_q;
                    if (sel_null) begin
                        res_cls_q <= to_stack ? FC_GP : FC_NONE;
                    end else if (sel_oor) begin
                        res_cls_q <= FC_GP;
                    end else begin
                        res_cls_q <= FC_NONE;
                    end
                end
                S_FETCH_LO: if (mem_rvalid) lo_q <= mem_rdata;
                S_FETCH_HI: if (mem_rvalid) hi_q <= mem_rdata;
                S_CHECK: begin
                    res_cls_q         <= rights_cls;
                    res_entry_q.base  <= un_base;
                    res_entry_q.limit <= un_limit;
                    res_entry_q.big   <= un_big;
                end
                S_REPORT: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy        = (state_q != S_IDLE);
        mem_req     = 1'b0;
        mem_addr    = '0;
        done        = 1'b0;
        fault       = 1'b0;
        fault_class = FC_NONE;
        err_code    = '0;
        cw_en       = 1'b0;
        cw_idx      = dest_q;
        cw_sel      = res_entry_q.sel;
        cw_base     = res_entry_q.base;
        cw_limit    = res_entry_q.limit;
        cw_big      = res_entry_q.big;
        unique case (state_q)
            S_FETCH_LO: begin
                mem_req  = 1'b1;
                mem_addr = lo_addr;
            end
            S_FETCH_HI: begin
                mem_req  = 1'b1;
                mem_addr = hi_addr;
            end
            S_REPORT: begin
                done = 1'b1;
                if (res_cls_q != FC_NONE) begin
                    fault       = 1'b1;
                    fault_class = res_cls_q;
                    err_code    = {sel_q[SEL_W-1:2], 2'b00};
                end else begin
                    cw_en = 1'b1;
                end
            end
            S_IDLE, S_DECODE, S_CHECK: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/seg_load_unit_chk.sv
module seg_load_unit_chk #(
    parameter int SEG_ID_W = 3,
    parameter int STACK_ID = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                mem_req,
    input logic                done,
    input logic                fault,
    input logic [1:0]          fault_class,
    input logic [15:0]         err_code,
    input logic                cw_en,
    input logic [15:0]         cw_sel,
    input logic [31:0]         cw_base,
    input logic [31:0]         cw_limit,
    input logic [SEG_ID_W-1:0] dest_q,
    input logic [31:0]         hi_q
);
    // R12
    excl_write_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cw_en |-> !fault);

    // R12
    single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    err_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (err_code[1:0] == 2'b00));

    // R8
    stack_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && fault_class == 2'd3) |-> (dest_q == SEG_ID_W'(STACK_ID)));

    // R2
    null_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_en && cw_sel[15:2] == 14'd0) |-> (cw_base == 32'd0 && cw_limit == 32'd0));

    // R10
    gran_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_en && cw_sel[15:2] != 14'd0 && hi_q[23]) |-> (cw_limit[11:0] == 12'hFFF));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !done));

endmodule

bind seg_load_unit seg_load_unit_chk #(
    .SEG_ID_W (SEG_ID_W),
    .STACK_ID (STACK_ID)
) u_chk_bind (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .mem_req     (mem_req),
    .done        (done),
    .fault       (fault),
    .fault_class (fault_class),
    .err_code    (err_code),
    .cw_en       (cw_en),
    .cw_sel      (cw_sel),
    .cw_base     (cw_base),
    .cw_limit    (cw_limit),
    .dest_q      (dest_q),
    .hi_q        (hi_q)
);

// File: tb/sim_seg_load_unit.sv
module sim_seg_load_unit;
    localparam int ADDR_W   = 32;
    localparam int SEG_ID_W = 3;
    localparam int STACK_ID = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [15:0]         sel = '0;
    logic [SEG_ID_W-1:0] dest_id = '0;
    logic [ADDR_W-1:0]   tbl_base = '0;
    logic [ADDR_W-1:0]   tbl_limit = '0;
    logic                busy, mem_req, done, fault, cw_en, cw_big;
    logic [ADDR_W-1:0]   mem_addr;
    logic                mem_rvalid = 1'b0;
    logic [31:0]         mem_rdata = '0;
    logic [1:0]          fault_class;
    logic [15:0]         err_code, cw_sel;
    logic [SEG_ID_W-1:0] cw_idx;
    logic [31:0]         cw_base, cw_limit;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // memory model contents for the current request
    logic [ADDR_W-1:0] m_lo_addr, m_hi_addr;
    logic [31:0]       m_lo, m_hi;
    int                reads = 0;
    int                bad_addr = 0;
    int                lat = 0;

    always #5 clk = ~clk;

    seg_load_unit #(.ADDR_W(ADDR_W), .SEG_ID_W(SEG_ID_W), .STACK_ID(STACK_ID)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .dest_id(dest_id),
        .tbl_base(tbl_base), .tbl_limit(tbl_limit), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .fault(fault),
        .fault_class(fault_class), .err_code(err_code), .cw_en(cw_en),
        .cw_idx(cw_idx), .cw_sel(cw_sel), .cw_base(cw_base),
        .cw_limit(cw_limit), .cw_big(cw_big)
    );

    // read responder with random latency, driven at falling edges
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rvalid) begin
                mem_rvalid = 1'b0;
            end else if (mem_req) begin
                if (lat == 0) begin
                    if (mem_addr == m_lo_addr)      mem_rdata = m_lo;
                    else if (mem_addr == m_hi_addr && reads == 1) mem_rdata = m_hi;
                    else begin
                        mem_rdata = 32'hBAD0_BAD0;
                        bad_addr++;
                    end
                    mem_rvalid = 1'b1;
                    reads++;
                    lat = $urandom_range(0, 3);
                end else begin
                    lat--;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // reference outcome from the requirements
    function automatic void model(input logic [15:0] s, input logic [SEG_ID_W-1:0] d,
                                  input logic [31:0] tlim, input logic [31:0] lo,
                                  input logic [31:0] hi, output logic [1:0] cls,
                                  output logic [31:0] base, output logic [31:0] lim,
                                  output logic big, output int nreads);
        bit stk;
        logic [32:0] last;
        logic [19:0] raw;
        stk = (d == SEG_ID_W'(STACK_ID));
        cls = 2'd0; base = '0; lim = '0; big = 1'b0; nreads = 0;
        last = {17'd0, s[15:3], 3'b000} + 33'd7;
        if (s[15:2] == 14'd0) begin
            cls = stk ? 2'd1 : 2'd0;
            return;
        end
        if (last > {1'b0, tlim}) begin
            cls = 2'd1;
            return;
        end
        nreads = 2;
        if (!hi[12] || (hi[11] && !hi[9]))       cls = 2'd1;
        else if (stk && (hi[11] || !hi[9]))      cls = 2'd1;
        else if (!hi[15])                        cls = stk ? 2'd3 : 2'd2;
        base = {hi[31:24], hi[7:0], lo[31:16]};
        raw  = {hi[19:16], lo[15:0]};
        lim  = hi[23] ? {raw, 12'hFFF} : {12'd0, raw};
        big  = hi[22];
    endfunction

    task automatic run_one(input logic [15:0] s, input logic [SEG_ID_W-1:0] d,
                           input logic [31:0] tb, input logic [31:0] tl,
                           input logic [31:0] lo, input logic [31:0] hi,
                           input bit disturb, input string tag);
        logic [1:0] ecls; logic [31:0] ebase, elim; logic ebig; int enr;
        int guard;
        model(s, d, tl, lo, hi, ecls, ebase, elim, ebig, enr);
        m_lo_addr = tb + {16'd0, s[15:3], 3'b000};
        m_hi_addr = m_lo_addr + 32'd4;
        m_lo = lo; m_hi = hi; reads = 0; bad_addr = 0;
        @(negedge clk);
        sel = s; dest_id = d; tbl_base = tb; tbl_limit = tl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            // R12: a second strobe while busy must be ignored
            chk(busy == 1'b1, "R12", "busy after start", {31'd0, busy}, 32'd1);
            sel = ~s; dest_id = ~d; tbl_limit = 32'd0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk(done == 1'b1, "R12", {tag, " done seen"}, {31'd0, done}, 32'd1);
        chk(reads == enr, "R4", {tag, " read count"}, reads, enr);
        chk(bad_addr == 0, "R4", {tag, " read address"}, bad_addr, 0);
        if (ecls != 2'd0) begin
            chk(fault && !cw_en, "R12", {tag, " fault without write"},
                {30'd0, fault, cw_en}, 32'd2);
            chk(fault_class == ecls, "R8", {tag, " fault class (R3 R4 R6 R7)"},
                fault_class, ecls);
            chk(err_code == {s[15:2], 2'b00}, "R5", {tag, " error code"},
                err_code, {16'd0, s[15:2], 2'b00});
        end else begin
            chk(cw_en && !fault, "R12", {tag, " write without fault"},
                {30'd0, fault, cw_en}, 32'd1);
            chk(cw_idx == d && cw_sel == s, "R12", {tag, " entry id and selector"},
                {13'd0, cw_idx, cw_sel}, {13'd0, d, s});
            chk(cw_base == ebase, "R9", {tag, " base (R2)"}, cw_base, ebase);
            chk(cw_limit == elim, "R10", {tag, " limit (R2)"}, cw_limit, elim);
            chk(cw_big == ebig, "R11", {tag, " 32-bit flag"}, {31'd0, cw_big}, {31'd0, ebig});
        end
        @(negedge clk);
        chk(!done, "R12", {tag, " single pulse"}, {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] hi_ok;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !mem_req && !cw_en && !fault, "R1", "reset quiet",
            {27'd0, busy, done, mem_req, cw_en, fault}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R1", "idle after reset", {30'd0, busy, done}, 32'd0);

        hi_ok = 32'h12CF_9234; // present, data, writable, gran, big
        // R2 null into data register
        run_one(16'h0003, 3'd1, 32'h1000, 32'hFFFF, 32'h0, hi_ok, 0, "R2 null data");
        // R3 null into stack register
        run_one(16'h0002, 3'd2, 32'h1000, 32'hFFFF, 32'h0, hi_ok, 0, "R3 null stack");
        // R4 boundary: last byte equals limit, then one past
        run_one(16'h0018, 3'd0, 32'h2000, 32'h001F, 32'hABCD_1234, hi_ok, 0, "R4 edge in");
        run_one(16'h0018, 3'd0, 32'h2000, 32'h001E, 32'hABCD_1234, hi_ok, 0, "R4 edge out");
        // R6 system descriptor and unreadable code
        run_one(16'h0020, 3'd1, 32'h0, 32'hFFFF, 32'h0, 32'h0000_8200, 0, "R6 system");
        run_one(16'h0020, 3'd1, 32'h0, 32'hFFFF, 32'h0, 32'h0000_9800, 0, "R6 code noread");
        // R7 readable code and read-only data into stack
        run_one(16'h0028, 3'd2, 32'h0, 32'hFFFF, 32'h0, 32'h0000_9A00, 0, "R7 code stack");
        run_one(16'h0028, 3'd2, 32'h0, 32'hFFFF, 32'h0, 32'h0000_9000, 0, "R7 ro stack");
        // R8 not present, both classes
        run_one(16'h0030, 3'd2, 32'h0, 32'hFFFF, 32'h0, 32'h0000_1200, 0, "R8 stack np");
        run_one(16'h0030, 3'd3, 32'h0, 32'hFFFF, 32'h0, 32'h0000_1200, 0, "R8 data np");
        // R9 R10 R11 byte-granular entry, then disturbed request
        run_one(16'h0039, 3'd4, 32'h4000, 32'hFFFF, 32'h5678_9ABC, 32'hEF05_9A12, 0, "R10 bytegran");
        run_one(16'h0040, 3'd2, 32'h4000, 32'hFFFF, 32'h1111_2222, hi_ok, 1, "R12 disturb");

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic [15:0] s; logic [SEG_ID_W-1:0] d; logic [31:0] tl, hi, lo;
            s  = 16'($urandom);
            if ($urandom_range(0, 7) == 0) s = {14'd0, 2'($urandom)};
            d  = SEG_ID_W'($urandom_range(0, 5));
            tl = ($urandom_range(0, 1) == 1) ? 32'hFFFF : 32'($urandom_range(0, 16'hFFFF));
            lo = $urandom;
            hi = $urandom;
            if ($urandom_range(0, 1) == 1) hi[15:8] = 8'h92;
            run_one(s, d, 32'($urandom) & 32'hFFFF_FFF8, tl, lo, hi, ($urandom_range(0, 9) == 0), "R9 random");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule